// File: doc/BRIEF.md
# Multicycle Unsigned Long Multiplier with Status Flags

This unit multiplies two 32-bit unsigned operands into a 64-bit product. The product leaves the unit as two words: a high word for product bits 63..32 and a low word for bits 31..0. The unit works through the second operand (the multiplier) eight bits per cycle, so a full multiply takes four step cycles. It stops as soon as the unprocessed multiplier bits are all zero. The first operand (the multiplicand) never affects how many cycles the unit takes.

A caller pulses `start_i` while the unit is idle. In the same cycle it presents the operands, a condition-passed bit, a set-flags bit and the current four status flags. When the unit finishes, it raises `done_o` for one cycle. In that cycle it shows the result words, the write enables for both words and the outgoing flag vector.

The negative and zero flags are updated from the 64-bit result only when the condition passed and set-flags is high. Carry and overflow always leave the unit unchanged. A failed condition suppresses every write.

Top module: `wide_umul_unit`

## Requirements
- R1: `hi_o` carries bits 63..32 and `lo_o` carries bits 31..0 of the unsigned product of `mcand_i` and `mplier_i`, presented in the cycle where `done_o` is high.
- R2: When `cond_ok_i` was low at the accepted start, `hi_we_o` and `lo_we_o` stay low in the done cycle and `flags_o` equals the captured `flags_i`. When the condition passed, both enables are high in the done cycle.
- R3: The flag vector is ordered bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. When the condition passed and `set_flags_i` was high, N in `flags_o` equals bit 31 of the high word.
- R4: Under the same update condition, Z is 1 exactly when both the high word and the low word are zero. A zero low word with a nonzero high word gives Z = 0.
- R5: C and V in `flags_o` always equal the C and V that were captured at start, for every combination of condition and set-flags.
- R6: When `set_flags_i` was low, `flags_o` equals the captured `flags_i` in all four bits.
- R7: The number of step cycles is the index of the highest nonzero byte of the multiplier plus one. A zero multiplier takes 1 step cycle. A multiplier with a nonzero top byte takes 4. The multiplicand has no effect on the count.
- R8: `busy_o` is high in every step cycle and low in the done cycle. `done_o` is a single-cycle pulse in the cycle right after the last step cycle.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored: the running operation completes with its own operands and timing.
- R10: After reset, `busy_o`, `done_o`, both write enables, both result words and `flags_o` are all zero. A reset during an operation returns the unit to idle with no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| mcand_i | input | 32 | Multiplicand, unsigned |
| mplier_i | input | 32 | Multiplier, unsigned; sets the cycle count |
| cond_ok_i | input | 1 | Condition passed; low suppresses all writes |
| set_flags_i | input | 1 | Request N/Z update from the result |
| flags_i | input | 4 | Incoming flags {N,Z,C,V} |
| busy_o | output | 1 | High during step cycles |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Product bits 63..32 |
| lo_o | output | 32 | Product bits 31..0 |
| hi_we_o | output | 1 | Write enable for the high word |
| lo_we_o | output | 1 | Write enable for the low word |
| flags_o | output | 4 | Outgoing flags {N,Z,C,V} |

## Verification
The bench sweeps multipliers whose highest nonzero byte sits at each of the four positions, plus a zero multiplier. A unit that let the multiplicand drive termination, or that checked the wrong end of the shift register, would report the wrong cycle count or drop upper partial products. Products with a zero low word but a nonzero high word, and products of 2^63 or more, catch a Z flag taken from one word only and an N flag taken from the wrong bit. Vectors with a failed condition or a clear set-flags bit, given flag inputs with C and V set, expose any leak of a write enable or a clobbered carry. A start pulse during a run and a mid-run reset show whether a design restarts or corrupts its operands, or emits a stray done.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  // flag vector bit positions
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_V = 0;
  localparam int unsigned FLG_W = 4;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // Replace N and Z when upd is set; C and V always pass through.
  function automatic logic [FLG_W-1:0] merge_flags(
    input logic [FLG_W-1:0] old_f,
    input logic             upd,
    input logic             neg,
    input logic             zero
  );
    logic [FLG_W-1:0] f;
    f = old_f;
    if (upd) begin
      f[FLG_N] = neg;
      f[FLG_Z] = zero;
    end
    return f;
  endfunction

endpackage

// File: rtl/wmul_seq.sv
module wmul_seq
  import wmul_pkg::*;
#(
  parameter int unsigned STEPS      = 4,
  parameter bit          EARLY_EXIT = 1'b1,
  localparam int unsigned CNT_W     = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rest_zero,
  output logic             accept,
  output logic             step,
  output logic             finish,
  output logic [CNT_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(STEPS - 1);

  seq_state_e state_q;
  logic       exit_ok;

  generate
    if (EARLY_EXIT) begin : g_early
      assign exit_ok = rest_zero;
    end else begin : g_full
      assign exit_ok = 1'b0;
    end
  endgenerate

  assign busy   = (state_q == SEQ_RUN);
  assign accept = start && (state_q == SEQ_IDLE);
  assign step   = busy;
  assign finish = busy && ((idx == LAST_IDX) || exit_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_RUN;
            idx     <= '0;
          end
        end
        SEQ_RUN: begin
          if (finish) begin
            state_q <= SEQ_IDLE;
            done    <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wmul_datapath.sv
module wmul_datapath #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIGIT_W = 8,
  parameter int unsigned CNT_W   = 2,
  localparam int unsigned ACC_W  = 2 * DATA_W,
  localparam int unsigned PP_W   = DATA_W + DIGIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [CNT_W-1:0]  idx,
  input  logic [DATA_W-1:0] mcand,
  input  logic [DATA_W-1:0] mplier,
  output logic [ACC_W-1:0]  acc_nxt,
  output logic              rest_zero
);

  logic [DATA_W-1:0] mc_q;
  logic [DATA_W-1:0] rem_q;
  logic [ACC_W-1:0]  acc_q;
  logic [PP_W-1:0]   row [DIGIT_W];
  logic [PP_W-1:0]   pp;
  logic [ACC_W-1:0]  pp_shifted;

  // one gated, shifted copy of the multiplicand per digit bit
  generate
    for (genvar g = 0; g < DIGIT_W; g++) begin : g_row
      assign row[g] = rem_q[g] ? (PP_W'(mc_q) << g) : '0;
    end
  endgenerate

  always_comb begin
    pp = '0;
    for (int k = 0; k < DIGIT_W; k++) begin
      pp = pp + row[k];
    end
  end

  assign pp_shifted = {{(ACC_W - PP_W){1'b0}}, pp} << (int'(idx) * DIGIT_W);
  assign acc_nxt    = acc_q + pp_shifted;
  assign rest_zero  = ((rem_q >> DIGIT_W) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= '0;
      rem_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      mc_q  <= mcand;
      rem_q <= mplier;
      acc_q <= '0;
    end else if (step) begin
      rem_q <= rem_q >> DIGIT_W;
      acc_q <= acc_nxt;
    end
  end

endmodule

// File: rtl/wmul_flag_gen.sv
module wmul_flag_gen
  import wmul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ACC_W = 2 * DATA_W
) (
  input  logic [ACC_W-1:0] result,
  input  logic             cond_ok,
  input  logic             set_flags,
  input  logic [FLG_W-1:0] old_flags,
  output logic [FLG_W-1:0] new_flags
);

  logic upd;
  logic neg;
  logic zero;

  assign upd  = cond_ok && set_flags;
  assign neg  = result[ACC_W-1];
  assign zero = (result[ACC_W-1:DATA_W] == '0) && (result[DATA_W-1:0] == '0);

  assign new_flags = merge_flags(old_flags, upd, neg, zero);

endmodule

// File: rtl/wide_umul_unit.sv
module wide_umul_unit
  import wmul_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIGIT_W    = 8,
  parameter bit          EARLY_EXIT = 1'b1,
  localparam int unsigned STEPS     = DATA_W / DIGIT_W,
  localparam int unsigned CNT_W     = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int unsigned ACC_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] mplier_i,
  input  logic              cond_ok_i,
  input  logic              set_flags_i,
  input  logic [3:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              hi_we_o,
  output logic              lo_we_o,
  output logic [3:0]        flags_o
);

  // named internal events, visible to the bound checker
  logic             accept_evt;
  logic             step_evt;
  logic             finish_evt;
  logic             rest_zero;
  logic [CNT_W-1:0] step_idx;
  logic [ACC_W-1:0] acc_nxt;
  logic [3:0]       flags_new;

  logic             cond_lat;
  logic             sf_lat;
  logic [3:0]       flags_lat;

  logic [DATA_W-1:0] hi_q, lo_q;
  logic              we_q;
  logic [3:0]        flags_q;

  wmul_seq #(
    .STEPS      (STEPS),
    .EARLY_EXIT (EARLY_EXIT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .rest_zero (rest_zero),
    .accept    (accept_evt),
    .step      (step_evt),
    .finish    (finish_evt),
    .idx       (step_idx),
    .busy      (busy_o),
    .done      (done_o)
  );

  wmul_datapath #(
    .DATA_W  (DATA_W),
    .DIGIT_W (DIGIT_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_evt),
    .step      (step_evt),
    .idx       (step_idx),
    .mcand     (mcand_i),
    .mplier    (mplier_i),
    .acc_nxt   (acc_nxt),
    .rest_zero (rest_zero)
  );

  wmul_flag_gen #(
    .DATA_W (DATA_W)
  ) u_flags (
    .result    (acc_nxt),
    .cond_ok   (cond_lat),
    .set_flags (sf_lat),
    .old_flags (flags_lat),
    .new_flags (flags_new)
  );

  // capture control inputs at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_lat  <= 1'b0;
      sf_lat    <= 1'b0;
      flags_lat <= '0;
    end else if (accept_evt) begin
      cond_lat  <= cond_ok_i;
      sf_lat    <= set_flags_i;
      flags_lat <= flags_i;
    end
  end

  // result and flag registers, loaded on the last step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (finish_evt) begin
        hi_q    <= acc_nxt[ACC_W-1:DATA_W];
        lo_q    <= acc_nxt[DATA_W-1:0];
        we_q    <= cond_lat;
        flags_q <= flags_new;
      end
    end
  end

  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign hi_we_o = we_q;
  assign lo_we_o = we_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/wmul_checker.sv
module wmul_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEPS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              hi_we_o,
  input logic              lo_we_o,
  input logic [DATA_W-1:0] hi_o,
  input logic [DATA_W-1:0] lo_o,
  input logic [3:0]        flags_o,
  input logic              cond_lat,
  input logic              sf_lat,
  input logic [3:0]        flags_lat
);

  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 8'd1;
    else             run_cnt <= '0;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_cnt < 8'(STEPS))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o)); // R9

  AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_o || lo_we_o) |-> done_o); // R2

  AST_NO_WRITE_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cond_lat) |-> (!hi_we_o && !lo_we_o && flags_o == flags_lat)); // R2

  AST_N_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cond_lat && sf_lat) |-> (flags_o[3] == hi_o[DATA_W-1])); // R3

  AST_Z_BOTH_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cond_lat && sf_lat) |-> (flags_o[2] == (hi_o == '0 && lo_o == '0))); // R4

  AST_CV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flags_o[1:0] == flags_lat[1:0])); // R5

  AST_PASS_NO_SF: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sf_lat) |-> (flags_o == flags_lat)); // R6

endmodule

bind wide_umul_unit wmul_checker #(
  .DATA_W (DATA_W),
  .STEPS  (STEPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .hi_we_o   (hi_we_o),
  .lo_we_o   (lo_we_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o),
  .flags_o   (flags_o),
  .cond_lat  (cond_lat),
  .sf_lat    (sf_lat),
  .flags_lat (flags_lat)
);

// File: tb/wide_umul_unit_test.sv
`timescale 1ns/1ps
module wide_umul_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mcand_i = '0;
  logic [31:0] mplier_i = '0;
  logic        cond_ok_i = 1'b0;
  logic        set_flags_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        busy_o, done_o, hi_we_o, lo_we_o;
  logic [31:0] hi_o, lo_o;
  logic [3:0]  flags_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wide_umul_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .cond_ok_i(cond_ok_i), .set_flags_i(set_flags_i),
    .flags_i(flags_i), .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o),
    .lo_o(lo_o), .hi_we_o(hi_we_o), .lo_we_o(lo_we_o), .flags_o(flags_o)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_MC [NV] = '{
    32'hFFFF_FFFF, 32'h0000_0000, 32'hDEAD_BEEF, 32'h1234_5678,
    32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'hABCD_EF01,
    32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_MP [NV] = '{
    32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000, 32'h0000_00FF,
    32'h0000_0002, 32'h0001_0000, 32'h0000_FF00, 32'h8765_4321,
    32'h0000_0000, 32'h8000_0000, 32'h0000_0100, 32'h8000_0000};
  // {cond, set_flags, N, Z, C, V}
  localparam logic [5:0] V_CTL [NV] = '{
    6'b11_0011, 6'b11_0000, 6'b11_1010, 6'b10_0101,
    6'b11_0100, 6'b11_1111, 6'b11_0001, 6'b01_0110,
    6'b10_1111, 6'b11_0010, 6'b11_1001, 6'b11_1100};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_steps(input logic [31:0] mp);
    int n = 1;
    for (int b = 1; b < 4; b++) if (mp[8*b +: 8] != 8'h00) n = b + 1;
    return n;
  endfunction

  // R1..R8: run one operation and check every output in the done cycle
  task automatic run_op(input logic [31:0] mc, input logic [31:0] mp,
                        input logic [5:0] ctl, input bit poke_start);
    logic [63:0] prod;
    logic [3:0]  exp_f;
    int          n;
    bit          busy_gap;
    prod  = {32'h0, mc} * {32'h0, mp};
    exp_f = ctl[3:0];
    if (ctl[5] && ctl[4]) begin
      exp_f[3] = prod[63];
      exp_f[2] = (prod == 64'h0);
    end
    @(negedge clk);
    mcand_i = mc; mplier_i = mp; cond_ok_i = ctl[5];
    set_flags_i = ctl[4]; flags_i = ctl[3:0]; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 0; busy_gap = 1'b0;
    while (n < 8 && !done_o) begin
      if (!busy_o) busy_gap = 1'b1;
      if (poke_start && n == 1) begin
        // R9: second request while busy, different operands
        mcand_i = 32'h7; mplier_i = 32'h9; cond_ok_i = ~ctl[5];
        set_flags_i = ~ctl[4]; flags_i = ~ctl[3:0]; start_i = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end
    check(n == exp_steps(mp), "R7", "step cycles", 64'(n), 64'(exp_steps(mp)));
    check(!busy_gap && !busy_o, "R8", "busy in steps, low at done", {busy_gap, busy_o}, 64'h0);
    check({hi_o, lo_o} == prod, poke_start ? "R9" : "R1", "product", {hi_o, lo_o}, prod);
    check(hi_we_o == ctl[5] && lo_we_o == ctl[5], "R2", "write enables",
          {hi_we_o, lo_we_o}, {2{ctl[5]}});
    check(flags_o[3] == exp_f[3], "R3", "N flag", 64'(flags_o), 64'(exp_f));
    check(flags_o[2] == exp_f[2], "R4", "Z flag", 64'(flags_o), 64'(exp_f));
    check(flags_o[1:0] == ctl[1:0], "R5", "C/V kept", 64'(flags_o[1:0]), 64'(ctl[1:0]));
    if (!ctl[4] || !ctl[5])
      check(flags_o == ctl[3:0], ctl[4] ? "R2" : "R6", "flags unchanged",
            64'(flags_o), 64'(ctl[3:0]));
    @(posedge clk);
    @(negedge clk);
    check(!done_o && !hi_we_o, "R8", "done one cycle", {done_o, hi_we_o}, 64'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && !hi_we_o && !lo_we_o, "R10", "reset controls",
          {busy_o, done_o, hi_we_o, lo_we_o}, 64'h0);
    check(hi_o == 0 && lo_o == 0 && flags_o == 0, "R10", "reset data",
          {hi_o, lo_o}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_op(V_MC[i], V_MP[i], V_CTL[i], 1'b0);

    // R9: start while busy is ignored (full-length op)
    run_op(32'h0000_0003, 32'h0100_0005, 6'b11_0011, 1'b1);
    // R7: multiplicand large with small multiplier still takes one step
    run_op(32'hFFFF_FFFF, 32'h0000_0001, 6'b11_0000, 1'b0);

    // R10: reset mid-run gives idle with no done
    @(negedge clk);
    mcand_i = 32'h5; mplier_i = 32'hFF00_0000; cond_ok_i = 1'b1; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !hi_we_o, "R10", "mid-run reset",
          {busy_o, done_o, hi_we_o}, 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!done_o && !busy_o, "R10", "no stray done", {done_o, busy_o}, 64'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule